// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Unit

This block joins two eight-input priority interrupt controllers, a primary and a secondary, into a sixteen-line system with a single interrupt request to the processor. Each controller resolves its own highest-priority pending level and presents it as a valid flag and a 3-bit level. This unit handles what lies between the two controllers and the processor. It forwards secondary requests onto primary input 2 as edges. It tracks the global line number, 0 to 15, that is currently requested, and it drives the processor request.

When the processor acknowledges, the unit produces one-cycle acknowledge strobes for the controller or controllers that own the line. It also registers an 8-bit vector. The vector is formed from the owning controller's 5-bit vector base in the upper bits and the level in the lower three bits. A combined status read polls the primary controller first and, if needed, the secondary controller. It returns the polled number, emits clear strobes for the in-service and request bits, and tells the primary controller to select its in-service register for later reads.

Top module: `cas_vector_unit`

## Requirements
- R1: While `sec_valid_i` is high, `cas_line_o` goes high one clock after it is sampled, drops low the next clock, and repeats. This gives a fresh rising edge every two clocks. One clock after `sec_valid_i` is sampled low, `cas_line_o` is low. Reset value is low.
- R2: One clock after sampling, `req_num_o` equals 8 + `sec_level_i` when `pri_level_i` equals 2 (the cascade input). Otherwise it equals `pri_level_i`.
- R3: One clock after sampling, `irq_o` equals `pri_valid_i`.
- R4: `req_num_o` is re-evaluated every clock. A new primary level presented before acknowledge replaces the previous number on the next clock.
- R5: For an acknowledge (`ack_i` high) while `irq_o` is high and `req_num_o` ≥ 8, the following hold in the same cycle: `pri_ack_o`=1 with `pri_ack_lvl_o`=2, and `sec_ack_o`=1 with `sec_ack_lvl_o`=`req_num_o` mod 8. On the next clock, `vec_o` = {`sec_base_i`, level}.
- R6: For an acknowledge while `irq_o` is high and `req_num_o` < 8, only `pri_ack_o` pulses, with `pri_ack_lvl_o`=`req_num_o`. On the next clock, `vec_o` = {`pri_base_i`, level}.
- R7: `vec_o` is 0 after reset and changes only on the clock that samples `ack_i` high.
- R8: For a status read (`poll_i` high, `ack_i` low) with `pri_valid_i` high at a level other than 2, the following hold in the same cycle: `pri_clr_o`=1 at `pri_clr_lvl_o`=`pri_level_i`, `sec_clr_o`=0, and `isr_sel_o`=1. On the next clock, `poll_num_o`=`pri_level_i`.
- R9: For a status read whose primary result is 2, `pri_clr_o` pulses at level 2. The secondary is then polled. On the next clock, `poll_num_o`=8 + the secondary result, where the secondary result is `sec_level_i` if `sec_valid_i` is high (and `sec_clr_o` then pulses at that level), else 7.
- R10: A status read with `pri_valid_i` low gives `poll_num_o`=7 and no clear strobes.
- R11: When `ack_i` and `poll_i` are high in the same cycle, the acknowledge is carried out. The status read is dropped: no clear strobes, no `isr_sel_o`, and `poll_num_o` unchanged.
- R12: An acknowledge while `irq_o` is low pulses no acknowledge strobe. On the next clock, `vec_o` = {`pri_base_i`, 7}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_valid_i | input | 1 | Primary controller has a resolved request |
| pri_level_i | input | 3 | Primary resolved level |
| sec_valid_i | input | 1 | Secondary controller has a resolved request |
| sec_level_i | input | 3 | Secondary resolved level |
| pri_base_i | input | 5 | Primary vector base (upper vector bits) |
| sec_base_i | input | 5 | Secondary vector base (upper vector bits) |
| ack_i | input | 1 | Processor acknowledge strobe |
| poll_i | input | 1 | Combined status read strobe |
| cas_line_o | output | 1 | Drive for primary input 2 |
| irq_o | output | 1 | Processor interrupt request |
| req_num_o | output | 4 | Currently requested global line |
| pri_ack_o | output | 1 | Acknowledge strobe to primary |
| pri_ack_lvl_o | output | 3 | Level acknowledged in primary |
| sec_ack_o | output | 1 | Acknowledge strobe to secondary |
| sec_ack_lvl_o | output | 3 | Level acknowledged in secondary |
| vec_o | output | 8 | Registered vector of last acknowledge |
| pri_clr_o | output | 1 | Poll clear strobe to primary |
| pri_clr_lvl_o | output | 3 | Level cleared in primary |
| sec_clr_o | output | 1 | Poll clear strobe to secondary |
| sec_clr_lvl_o | output | 3 | Level cleared in secondary |
| isr_sel_o | output | 1 | Primary read select to in-service register |
| poll_num_o | output | 4 | Registered result of last status read |

## Verification
The acknowledge and the combined status read can fall in the same clock, since both come from the processor side. The bench provokes this by raising `ack_i` and `poll_i` together while a primary request is pending. It then judges the result at the ports: in that cycle the acknowledge strobe must be present and all poll clear strobes and `isr_sel_o` absent, and on the next clock `vec_o` must carry the acknowledged vector while `poll_num_o` keeps its earlier value. The bench also acknowledges a secondary line while the cascade line is toggling, to show that the cascade edges do not disturb the two-controller acknowledge.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int unsigned LVL_W_DEF  = 3;
  localparam int unsigned VEC_W_DEF  = 8;
  localparam int unsigned CAS_IN_DEF = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_ACK  = 2'd1,
    OP_POLL = 2'd2
  } cas_op_e;
endpackage

// File: rtl/cas_edge_gen.sv
module cas_edge_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic line_o
);
  logic line_q;

  // high then low so each slave request period yields a new rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= req_i & ~line_q;
  end

  assign line_o = line_q;

  p_cas_return_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |=> !line_o);
endmodule

// File: rtl/cas_req_track.sv
module cas_req_track #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned CAS_IN = 2,
  localparam int unsigned NUM_W = LVL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pri_valid_i,
  input  logic [LVL_W-1:0] pri_level_i,
  input  logic [LVL_W-1:0] sec_level_i,
  output logic             irq_o,
  output logic [NUM_W-1:0] num_o
);
  logic             irq_q;
  logic [NUM_W-1:0] num_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      num_q <= '0;
    end else begin
      irq_q <= pri_valid_i;
      num_q <= (pri_level_i == LVL_W'(CAS_IN)) ? {1'b1, sec_level_i}
                                                : {1'b0, pri_level_i};
    end
  end

  assign irq_o = irq_q;
  assign num_o = num_q;

  p_irq_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_valid_i |=> irq_o);
  p_irq_drops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pri_valid_i |=> !irq_o);
endmodule

// File: rtl/cas_ack_ctl.sv
module cas_ack_ctl #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned CAS_IN = 2,
  localparam int unsigned NUM_W  = LVL_W + 1,
  localparam int unsigned BASE_W = VEC_W - LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              irq_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [BASE_W-1:0] pri_base_i,
  input  logic [BASE_W-1:0] sec_base_i,
  output logic              pri_ack_o,
  output logic [LVL_W-1:0]  pri_ack_lvl_o,
  output logic              sec_ack_o,
  output logic [LVL_W-1:0]  sec_ack_lvl_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic             from_sec;
  logic [LVL_W-1:0] lvl;
  logic [VEC_W-1:0] vec_d, vec_q;

  assign from_sec = num_i[NUM_W-1];
  assign lvl      = num_i[LVL_W-1:0];

  always_comb begin
    pri_ack_o     = go_i & irq_i;
    pri_ack_lvl_o = from_sec ? LVL_W'(CAS_IN) : lvl;
    sec_ack_o     = go_i & irq_i & from_sec;
    sec_ack_lvl_o = lvl;
    if (!irq_i)        vec_d = {pri_base_i, {LVL_W{1'b1}}};  // spurious
    else if (from_sec) vec_d = {sec_base_i, lvl};
    else               vec_d = {pri_base_i, lvl};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vec_q <= '0;
    else if (go_i) vec_q <= vec_d;
  end

  assign vec_o = vec_q;

  p_vec_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_i |=> $stable(vec_o));
  p_sec_needs_pri_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_ack_o |-> (pri_ack_o && pri_ack_lvl_o == LVL_W'(CAS_IN)));
endmodule

// File: rtl/cas_poll_ctl.sv
module cas_poll_ctl #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned CAS_IN = 2,
  localparam int unsigned NUM_W = LVL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             pri_valid_i,
  input  logic [LVL_W-1:0] pri_level_i,
  input  logic             sec_valid_i,
  input  logic [LVL_W-1:0] sec_level_i,
  output logic             pri_clr_o,
  output logic [LVL_W-1:0] pri_clr_lvl_o,
  output logic             sec_clr_o,
  output logic [LVL_W-1:0] sec_clr_lvl_o,
  output logic             isr_sel_o,
  output logic [NUM_W-1:0] num_o
);
  localparam logic [LVL_W-1:0] NONE = {LVL_W{1'b1}};

  logic [LVL_W-1:0] pri_res, sec_res;
  logic             chain;
  logic [NUM_W-1:0] num_q;

  always_comb begin
    pri_res = pri_valid_i ? pri_level_i : NONE;
    sec_res = sec_valid_i ? sec_level_i : NONE;
    chain   = pri_valid_i && (pri_level_i == LVL_W'(CAS_IN));
    // primary clear at the cascade level also covers the slave-poll clear of bit 2
    pri_clr_o     = go_i & pri_valid_i;
    pri_clr_lvl_o = pri_level_i;
    sec_clr_o     = go_i & chain & sec_valid_i;
    sec_clr_lvl_o = sec_level_i;
    isr_sel_o     = go_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   num_q <= '0;
    else if (go_i) num_q <= chain ? {1'b1, sec_res} : {1'b0, pri_res};
  end

  assign num_o = num_q;

  p_sec_clr_chain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_clr_o |-> (pri_clr_o && pri_clr_lvl_o == LVL_W'(CAS_IN)));
  p_poll_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_i |=> $stable(num_o));
endmodule

// File: rtl/cas_vector_unit.sv
module cas_vector_unit
  import cas_pkg::*;
#(
  parameter int unsigned LVL_W  = LVL_W_DEF,
  parameter int unsigned VEC_W  = VEC_W_DEF,
  parameter int unsigned CAS_IN = CAS_IN_DEF,
  localparam int unsigned NUM_W  = LVL_W + 1,
  localparam int unsigned BASE_W = VEC_W - LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pri_valid_i,
  input  logic [LVL_W-1:0]  pri_level_i,
  input  logic              sec_valid_i,
  input  logic [LVL_W-1:0]  sec_level_i,
  input  logic [BASE_W-1:0] pri_base_i,
  input  logic [BASE_W-1:0] sec_base_i,
  input  logic              ack_i,
  input  logic              poll_i,
  output logic              cas_line_o,
  output logic              irq_o,
  output logic [NUM_W-1:0]  req_num_o,
  output logic              pri_ack_o,
  output logic [LVL_W-1:0]  pri_ack_lvl_o,
  output logic              sec_ack_o,
  output logic [LVL_W-1:0]  sec_ack_lvl_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              pri_clr_o,
  output logic [LVL_W-1:0]  pri_clr_lvl_o,
  output logic              sec_clr_o,
  output logic [LVL_W-1:0]  sec_clr_lvl_o,
  output logic              isr_sel_o,
  output logic [NUM_W-1:0]  poll_num_o
);
  cas_op_e op;

  // acknowledge outranks a status read in the same cycle
  always_comb begin
    if (ack_i)       op = OP_ACK;
    else if (poll_i) op = OP_POLL;
    else             op = OP_IDLE;
  end

  cas_edge_gen u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (sec_valid_i),
    .line_o (cas_line_o)
  );

  cas_req_track #(.LVL_W(LVL_W), .CAS_IN(CAS_IN)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pri_valid_i (pri_valid_i),
    .pri_level_i (pri_level_i),
    .sec_level_i (sec_level_i),
    .irq_o       (irq_o),
    .num_o       (req_num_o)
  );

  cas_ack_ctl #(.LVL_W(LVL_W), .VEC_W(VEC_W), .CAS_IN(CAS_IN)) u_ack (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .go_i          (op == OP_ACK),
    .irq_i         (irq_o),
    .num_i         (req_num_o),
    .pri_base_i    (pri_base_i),
    .sec_base_i    (sec_base_i),
    .pri_ack_o     (pri_ack_o),
    .pri_ack_lvl_o (pri_ack_lvl_o),
    .sec_ack_o     (sec_ack_o),
    .sec_ack_lvl_o (sec_ack_lvl_o),
    .vec_o         (vec_o)
  );

  cas_poll_ctl #(.LVL_W(LVL_W), .CAS_IN(CAS_IN)) u_poll (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .go_i          (op == OP_POLL),
    .pri_valid_i   (pri_valid_i),
    .pri_level_i   (pri_level_i),
    .sec_valid_i   (sec_valid_i),
    .sec_level_i   (sec_level_i),
    .pri_clr_o     (pri_clr_o),
    .pri_clr_lvl_o (pri_clr_lvl_o),
    .sec_clr_o     (sec_clr_o),
    .sec_clr_lvl_o (sec_clr_lvl_o),
    .isr_sel_o     (isr_sel_o),
    .num_o         (poll_num_o)
  );

  p_ack_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && poll_i) |=> $stable(poll_num_o));
  p_ack_no_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> !(pri_clr_o || sec_clr_o || isr_sel_o));
endmodule

// File: tb/cas_vector_unit_tb.sv
module cas_vector_unit_tb_top;
  localparam int K_VEC = 0, K_POLL = 1, K_NUM = 2, K_IRQ = 3, K_CAS = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pri_valid_i = 0, sec_valid_i = 0, ack_i = 0, poll_i = 0;
  logic [2:0] pri_level_i = 0, sec_level_i = 0;
  logic [4:0] pri_base_i = 5'h04, sec_base_i = 5'h0E;
  logic       cas_line_o, irq_o, pri_ack_o, sec_ack_o, pri_clr_o, sec_clr_o, isr_sel_o;
  logic [3:0] req_num_o, poll_num_o;
  logic [2:0] pri_ack_lvl_o, sec_ack_lvl_o, pri_clr_lvl_o, sec_clr_lvl_o;
  logic [7:0] vec_o;

  int total = 0, bad = 0;
  bit finished = 0;
  int    k_q[$];
  int    e_q[$];
  string t_q[$];

  always #4 clk_i = ~clk_i;

  cas_vector_unit dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_next(int kind, int exp, string tag);
    k_q.push_back(kind); e_q.push_back(exp); t_q.push_back(tag);
  endtask

  function automatic int observe(int kind);
    case (kind)
      K_VEC:   return int'(vec_o);
      K_POLL:  return int'(poll_num_o);
      K_NUM:   return int'(req_num_o);
      K_IRQ:   return int'(irq_o);
      default: return int'(cas_line_o);
    endcase
  endfunction

  // monitor: compares everything queued before this edge
  initial begin
    forever begin
      @(posedge clk_i); #1;
      while (k_q.size() > 0) begin
        int k, e; string t;
        k = k_q.pop_front(); e = e_q.pop_front(); t = t_q.pop_front();
        chk(t, observe(k), e);
      end
    end
  end

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  initial begin
    step(); step();
    chk("reset R7 vec", vec_o, 0);
    chk("reset R1 cas", cas_line_o, 0);
    chk("reset R3 irq", irq_o, 0);
    chk("reset R9 poll", poll_num_o, 0);
    rst_ni = 1'b1;
    step();

    // R3 / R2 primary line
    pri_valid_i = 1; pri_level_i = 3'd5;
    expect_next(K_IRQ, 1, "R3 irq raised");
    expect_next(K_NUM, 5, "R2 primary number");
    step();
    // R2 secondary line; R1 cascade edges
    pri_level_i = 3'd2; sec_valid_i = 1; sec_level_i = 3'd3;
    expect_next(K_NUM, 11, "R2 secondary number");
    expect_next(K_CAS, 1, "R1 cascade high");
    step();
    expect_next(K_CAS, 0, "R1 cascade low");
    step();
    expect_next(K_CAS, 1, "R1 cascade high again");
    step();
    sec_valid_i = 0;
    expect_next(K_CAS, 0, "R1 cascade idle");
    step();
    // R4 re-evaluation before acknowledge
    pri_level_i = 3'd5;
    expect_next(K_NUM, 5, "R4 first number");
    step();
    pri_level_i = 3'd1;
    expect_next(K_NUM, 1, "R4 replaced number");
    step();
    // R6 primary acknowledge
    ack_i = 1;
    #1;
    chk("R6 pri_ack", pri_ack_o, 1);
    chk("R6 pri_ack_lvl", pri_ack_lvl_o, 1);
    chk("R6 no sec_ack", sec_ack_o, 0);
    expect_next(K_VEC, 8'h21, "R6 vector");
    step();
    ack_i = 0;
    // R5 secondary acknowledge with cascade toggling
    pri_level_i = 3'd2; sec_level_i = 3'd6; sec_valid_i = 1;
    step();
    ack_i = 1;
    #1;
    chk("R5 pri_ack", pri_ack_o, 1);
    chk("R5 pri_ack_lvl", pri_ack_lvl_o, 2);
    chk("R5 sec_ack", sec_ack_o, 1);
    chk("R5 sec_ack_lvl", sec_ack_lvl_o, 6);
    expect_next(K_VEC, 8'h76, "R5 vector");
    step();
    ack_i = 0; sec_valid_i = 0;
    // R7 hold
    pri_level_i = 3'd4;
    step(); step();
    expect_next(K_VEC, 8'h76, "R7 vector held");
    step();
    // R12 spurious
    pri_valid_i = 0;
    step();
    ack_i = 1;
    #1;
    chk("R12 no pri_ack", pri_ack_o, 0);
    chk("R12 no sec_ack", sec_ack_o, 0);
    expect_next(K_VEC, 8'h27, "R12 spurious vector");
    step();
    ack_i = 0;
    // R8 poll primary
    pri_valid_i = 1; pri_level_i = 3'd5; poll_i = 1;
    #1;
    chk("R8 pri_clr", pri_clr_o, 1);
    chk("R8 pri_clr_lvl", pri_clr_lvl_o, 5);
    chk("R8 no sec_clr", sec_clr_o, 0);
    chk("R8 isr_sel", isr_sel_o, 1);
    expect_next(K_POLL, 5, "R8 poll number");
    step();
    // R9 poll through cascade
    pri_level_i = 3'd2; sec_valid_i = 1; sec_level_i = 3'd4;
    #1;
    chk("R9 pri_clr_lvl", pri_clr_lvl_o, 2);
    chk("R9 pri_clr", pri_clr_o, 1);
    chk("R9 sec_clr", sec_clr_o, 1);
    chk("R9 sec_clr_lvl", sec_clr_lvl_o, 4);
    expect_next(K_POLL, 12, "R9 poll number");
    step();
    sec_valid_i = 0;
    #1;
    chk("R9 no sec_clr when empty", sec_clr_o, 0);
    expect_next(K_POLL, 15, "R9 empty secondary");
    step();
    // R10 nothing pending
    pri_valid_i = 0;
    #1;
    chk("R10 no pri_clr", pri_clr_o, 0);
    chk("R10 no sec_clr", sec_clr_o, 0);
    expect_next(K_POLL, 7, "R10 poll none");
    step();
    poll_i = 0;
    // R11 acknowledge and poll together
    pri_valid_i = 1; pri_level_i = 3'd3;
    step();
    ack_i = 1; poll_i = 1;
    #1;
    chk("R11 ack taken", pri_ack_o, 1);
    chk("R11 no pri_clr", pri_clr_o, 0);
    chk("R11 no isr_sel", isr_sel_o, 0);
    expect_next(K_VEC, 8'h23, "R11 vector");
    expect_next(K_POLL, 7, "R11 poll unchanged");
    step();
    ack_i = 0; poll_i = 0;
    step(); step();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule